// File: doc/BRIEF.md
# Triple-Redundant Accumulator Stage with Per-Domain Voting

This block is a pipeline stage hardened against single upsets. Three redundancy domains each hold a copy of an accumulator register and each compute the same small function: the register value plus that domain's copy of the input word. Every domain has its own bitwise majority voter on the three function results, and its register loads that voted value. A register that was upset is therefore rewritten with the agreed value on the next clock edge, so errors cannot build up across cycles. A second voter in each domain takes the majority of the three registers and drives that domain's output copy. No single voter is shared by all outputs.

Each domain also has a minority detector. It raises that domain's flag whenever its own register disagrees with both of the other two. The flag lasts one cycle for each corrected upset, so it can drive an external error counter directly. A test port flips one chosen bit in one chosen domain register at a clock edge, so that the correction path can be exercised.

The stage has no handshake. It loads on every clock edge and cannot be stalled, so there is no back-pressure to honour. The voting gives a correct result only while at most one domain is wrong. If two input copies carry the same wrong value, the vote follows them.

Top module: `tmr_reg_stage`

## Requirements
- R1: A synchronous active-high `rst` loads RESET_VAL (default 0) into all three registers. In the next cycle every `dout` copy equals RESET_VAL and `mismatch` is 0. Reset overrides a fault injection requested in the same cycle.
- R2: With `rst` low and all input copies equal to d, each clock edge makes the stored value the previous value plus d, modulo 2^WIDTH. The new value appears on all `dout` copies in the cycle after the edge.
- R3: Each register loads the bitwise majority of (q+din[0], q+din[1], q+din[2]). One wrong input copy is outvoted. When two copies carry the same wrong value, the result follows those two.
- R4: When `inj_en` is 1, `inj_dom`=k (0, 1 or 2 selects domains 0, 1 or 2) and `inj_bit`=b < WIDTH, register k stores the voted value XOR (1<<b) at that edge. `inj_dom`=3 changes nothing: `mismatch` stays 0 and `dout` follows R2.
- R5: In the cycle after an injection, all three `dout` copies still show the correct voted value.
- R6: `mismatch[k]` (bit k belongs to domain k) is 1 only in the cycle after an edge that injected into domain k. The next edge rewrites register k from the vote and clears the flag, unless that same edge injects into domain k again.
- R7: At most one `mismatch` bit is 1 in any cycle. Input copies that disagree never raise a flag.
- R8: The three `dout` copies are equal in every cycle outside reset.
- R9: Injections into different domains on consecutive edges each raise only the flag of the domain just hit. The earlier domain is repaired at the same edge that upsets the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all domains |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 3 x WIDTH | Input word, one copy per domain |
| inj_en | input | 1 | Fault injection strobe |
| inj_dom | input | 2 | Target domain for injection (3 = none) |
| inj_bit | input | $clog2(WIDTH) | Bit index flipped by injection |
| dout | output | 3 x WIDTH | Voted output word, one copy per domain |
| mismatch | output | 3 | Per-domain minority flag, one bit per domain |

## Verification
Two events can land on the same edge: the repair of a domain that was upset on the previous edge, and a fresh upset in a different domain. The bench provokes this with injections into domains 0, 1 and 2 on three consecutive edges. After each edge it expects only the newest domain's flag and an unchanged correct output. A second overlap is a reset together with an injection request. There the bench expects the reset value and no flag. Injection is never combined with a wrong input copy, because that would put two domains out of line at once.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_DOM   = 3;
  localparam int DOM_SEL_W = 2;
endpackage

// File: rtl/tmr_maj3.sv
module tmr_maj3 #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] c,
  output logic [WIDTH-1:0] y
);
  // Bitwise two-of-three vote.
  always_comb y = (a & b) | (a & c) | (b & c);
endmodule

// File: rtl/tmr_minority.sv
module tmr_minority #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] own,
  input  logic [WIDTH-1:0] peer_a,
  input  logic [WIDTH-1:0] peer_b,
  output logic             flag
);
  // Raised when some bit of this domain differs from both peers.
  always_comb flag = |((own ^ peer_a) & (own ^ peer_b));
endmodule

// File: rtl/tmr_domain.sv
module tmr_domain #(
  parameter int               WIDTH     = 8,
  parameter logic [WIDTH-1:0] RESET_VAL = '0,
  parameter int               IDX_W     = 3,
  parameter int               DOM_IDX   = 0
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [WIDTH-1:0]                    din,
  input  logic [tmr_pkg::NUM_DOM-1:0][WIDTH-1:0] q_all,
  input  logic [tmr_pkg::NUM_DOM-1:0][WIDTH-1:0] comb_all,
  input  logic                                inj_hit,
  input  logic [IDX_W-1:0]                    inj_bit,
  output logic [WIDTH-1:0]                    q,
  output logic [WIDTH-1:0]                    comb,
  output logic [WIDTH-1:0]                    dout,
  output logic                                err
);
  localparam int PEER_A = (DOM_IDX + 1) % tmr_pkg::NUM_DOM;
  localparam int PEER_B = (DOM_IDX + 2) % tmr_pkg::NUM_DOM;

  logic [WIDTH-1:0] next_val;
  logic [WIDTH-1:0] flip_mask;

  // Domain function (R2): accumulate own register with own input copy.
  always_comb comb = q + din;

  // Feedback voter (R3): the register reloads the agreed result, which repairs upsets (R6).
  tmr_maj3 #(.WIDTH(WIDTH)) u_next_vote (
    .a(comb_all[0]), .b(comb_all[1]), .c(comb_all[2]), .y(next_val)
  );

  always_comb flip_mask = WIDTH'(1) << inj_bit;

  always_ff @(posedge clk) begin
    if (rst)          q <= RESET_VAL;              // R1
    else if (inj_hit) q <= next_val ^ flip_mask;   // R4
    else              q <= next_val;
  end

  // Output voter (R5, R8).
  tmr_maj3 #(.WIDTH(WIDTH)) u_out_vote (
    .a(q_all[0]), .b(q_all[1]), .c(q_all[2]), .y(dout)
  );

  // Minority detector (R6, R7).
  tmr_minority #(.WIDTH(WIDTH)) u_minority (
    .own(q), .peer_a(q_all[PEER_A]), .peer_b(q_all[PEER_B]), .flag(err)
  );
endmodule

// File: rtl/tmr_reg_stage.sv
module tmr_reg_stage #(
  parameter int               WIDTH     = 8,
  parameter logic [WIDTH-1:0] RESET_VAL = '0,
  localparam int              IDX_W     = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [tmr_pkg::NUM_DOM-1:0][WIDTH-1:0] din,
  input  logic                                   inj_en,
  input  logic [tmr_pkg::DOM_SEL_W-1:0]          inj_dom,
  input  logic [IDX_W-1:0]                       inj_bit,
  output logic [tmr_pkg::NUM_DOM-1:0][WIDTH-1:0] dout,
  output logic [tmr_pkg::NUM_DOM-1:0]            mismatch
);
  import tmr_pkg::*;

  logic [NUM_DOM-1:0][WIDTH-1:0] q_all;
  logic [NUM_DOM-1:0][WIDTH-1:0] comb_all;
  logic [NUM_DOM-1:0]            inj_hit;

  for (genvar k = 0; k < NUM_DOM; k++) begin : g_dom
    // Selector value 3 matches no domain (R4).
    assign inj_hit[k] = inj_en && (inj_dom == DOM_SEL_W'(k));

    tmr_domain #(
      .WIDTH(WIDTH), .RESET_VAL(RESET_VAL), .IDX_W(IDX_W), .DOM_IDX(k)
    ) u_domain (
      .clk(clk), .rst(rst), .din(din[k]),
      .q_all(q_all), .comb_all(comb_all),
      .inj_hit(inj_hit[k]), .inj_bit(inj_bit),
      .q(q_all[k]), .comb(comb_all[k]),
      .dout(dout[k]), .err(mismatch[k])
    );
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int               WIDTH     = 8,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input logic                                   clk,
  input logic                                   rst,
  input logic                                   inj_en,
  input logic [tmr_pkg::DOM_SEL_W-1:0]          inj_dom,
  input logic [tmr_pkg::NUM_DOM-1:0][WIDTH-1:0] dout,
  input logic [tmr_pkg::NUM_DOM-1:0]            mismatch
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (dout[0] == RESET_VAL && dout[1] == RESET_VAL &&
             dout[2] == RESET_VAL && mismatch == '0));

  assert_single_flag_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mismatch));

  assert_copies_agree_R8: assert property (@(posedge clk) disable iff (rst)
    (dout[0] == dout[1]) && (dout[1] == dout[2]));

  for (genvar k = 0; k < tmr_pkg::NUM_DOM; k++) begin : g_dom_chk
    assert_flag_on_upset_R6: assert property (@(posedge clk) disable iff (rst)
      (inj_en && inj_dom == tmr_pkg::DOM_SEL_W'(k)) |=> mismatch[k]);

    assert_flag_repaired_R6: assert property (@(posedge clk) disable iff (rst)
      (mismatch[k] && !(inj_en && inj_dom == tmr_pkg::DOM_SEL_W'(k))) |=> !mismatch[k]);
  end
endmodule

bind tmr_reg_stage tmr_checker #(.WIDTH(WIDTH), .RESET_VAL(RESET_VAL)) u_tmr_checker (
  .clk(clk), .rst(rst), .inj_en(inj_en), .inj_dom(inj_dom),
  .dout(dout), .mismatch(mismatch)
);

// File: tb/test_tmr_reg_stage.sv
module test_tmr_reg_stage;
  localparam int W = 4;
  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [2:0][W-1:0] din = '0;
  logic             inj_en = 1'b0;
  logic [1:0]       inj_dom = 2'd0;
  logic [1:0]       inj_bit = 2'd0;
  logic [2:0][W-1:0] dout;
  logic [2:0]       mismatch;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  logic [W-1:0] acc;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_reg_stage #(.WIDTH(W)) i_tmr_reg_stage (
    .clk(clk), .rst(rst), .din(din), .inj_en(inj_en), .inj_dom(inj_dom),
    .inj_bit(inj_bit), .dout(dout), .mismatch(mismatch)
  );

  function automatic logic [W-1:0] vote3(logic [W-1:0] a, b, c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // Apply one cycle of stimulus at a falling edge; return at the next falling edge.
  task automatic step(input logic [W-1:0] a, b, c, input logic ie,
                      input logic [1:0] dom, input logic [1:0] bt, input logic r);
    din[0] = a; din[1] = b; din[2] = c;
    inj_en = ie; inj_dom = dom; inj_bit = bt; rst = r;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [W-1:0] exp, input logic [2:0] expflag);
    for (int k = 0; k < 3; k++) begin
      compared++;
      if (dout[k] !== exp) begin
        mismatched++;
        $display("FAIL %s: dout[%0d] actual %0h expected %0h", req, k, dout[k], exp);
      end
    end
    compared++;
    if (mismatch !== expflag) begin
      mismatched++;
      $display("FAIL %s: mismatch actual %b expected %b", req, mismatch, expflag);
    end
  endtask

  initial begin
    @(negedge clk);
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 1, 0, 0, 1);
    check("R1 reset", 0, 3'b000);
    acc = '0;

    // R2: accumulate with equal copies.
    for (int d = 0; d < 16; d++) begin
      step(W'(d), W'(d), W'(d), 0, 0, 0, 0);
      acc = acc + W'(d);
      check("R2 accumulate", acc, 3'b000);
    end

    // R3/R7: one wrong input copy, every domain, value and error pattern.
    for (int j = 0; j < 3; j++)
      for (int d = 0; d < 16; d++)
        for (int x = 1; x < 16; x++) begin
          logic [2:0][W-1:0] cp;
          cp[0] = W'(d); cp[1] = W'(d); cp[2] = W'(d);
          cp[j] = W'(d) ^ W'(x);
          step(cp[0], cp[1], cp[2], 0, 0, 0, 0);
          acc = vote3(acc + cp[0], acc + cp[1], acc + cp[2]);
          check("R3 R7 single bad copy", acc, 3'b000);
        end

    // R3: two equal wrong copies win.
    for (int j = 0; j < 3; j++)
      for (int d = 0; d < 16; d++) begin
        logic [2:0][W-1:0] cp;
        cp[0] = W'(d) ^ 4'h5; cp[1] = W'(d) ^ 4'h5; cp[2] = W'(d) ^ 4'h5;
        cp[j] = W'(d);
        step(cp[0], cp[1], cp[2], 0, 0, 0, 0);
        acc = acc + (W'(d) ^ 4'h5);
        check("R3 two bad copies", acc, 3'b000);
      end

    // R4/R5/R6: every domain and bit.
    for (int k = 0; k < 3; k++)
      for (int b = 0; b < W; b++) begin
        step(3, 3, 3, 1, 2'(k), 2'(b), 0);
        acc = acc + 4'd3;
        check("R4 R5 R6 upset flagged and masked", acc, 3'(1 << k));
        step(1, 1, 1, 0, 0, 0, 0);
        acc = acc + 4'd1;
        check("R6 repaired", acc, 3'b000);
      end

    // R4: selector 3 hits nothing.
    step(2, 2, 2, 1, 3, 1, 0);
    acc = acc + 4'd2;
    check("R4 no-domain selector", acc, 3'b000);

    // R6: same domain twice keeps the flag.
    step(1, 1, 1, 1, 1, 0, 0);
    acc = acc + 4'd1;
    check("R6 first upset", acc, 3'b010);
    step(1, 1, 1, 1, 1, 2, 0);
    acc = acc + 4'd1;
    check("R6 re-upset", acc, 3'b010);
    step(0, 0, 0, 0, 0, 0, 0);
    check("R6 cleared", acc, 3'b000);

    // R9: repair and new upset on the same edge.
    for (int k = 0; k < 3; k++) begin
      step(5, 5, 5, 1, 2'(k), 2'(3 - k), 0);
      acc = acc + 4'd5;
      check("R9 back-to-back upsets", acc, 3'(1 << k));
    end
    step(0, 0, 0, 0, 0, 0, 0);
    check("R9 final repair", acc, 3'b000);

    // R1: reset beats injection.
    step(7, 7, 7, 1, 0, 0, 1);
    acc = '0;
    check("R1 reset over injection", acc, 3'b000);
    step(6, 6, 6, 0, 0, 0, 0);
    acc = acc + 4'd6;
    check("R1 R2 after reset", acc, 3'b000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule